// File: doc/BRIEF.md
# Endpoint Packet Buffer Controller

This block keeps the bookkeeping for eight packet buffers, four on the transmit side and four on the receive side, whose storage lives in RAMs outside the block. Each direction has one shared write address, one shared read address and one shared write-data bus. A per-RAM active-low write strobe picks the RAM that takes a byte, and a read-select code picks the RAM whose output is used. Users issue byte-level write and read operations tagged with a USB endpoint number. The block maps the endpoint to a buffer, checks the buffer's state, and on acceptance drives the RAM control lines one cycle later.

A writer collects bytes into a data set and then commits it. Only committed sets can be read. The writer can rewind to drop an uncommitted set. The reader can rewind to re-read the current set from its start, or release the set to free its space.

Three buffers per direction are single-level: later commits append to the one readable set. The fourth buffer is larger and two-level. It queues up to two committed sets of independent length and keeps the boundary between them.

Top module: `epbuf_ctrl`

## Requirements
- R1: Transmit endpoints 7, 6, 5 and 0 map to buffers 3, 2, 1 and 0. Receive endpoints 3, 2, 1 and 0 map to buffers 3, 2, 1 and 0. Operations on any other endpoint number have no effect.
- R2: Write operation codes are 0 none, 1 push, 2 push-and-commit, 3 commit and 4 rewind. In the cycle after an accepted push, the byte is on the write-data bus, the write address holds the byte's position in that buffer's ring, and only strobe bit b (b = buffer number) is low. Strobe bits 4 to 6 stay high at all times.
- R3: A single-level buffer reports full once it holds SMALL_DEPTH bytes that have not been released. A push to a full buffer is ignored.
- R4: A buffer reports empty until a set is committed. A pop is ignored, with the read enable low, while the buffer is empty or after the whole current set has been read.
- R5: Read operation codes are 0 none, 1 pop, 2 pop-and-release, 3 release and 4 rewind. In the cycle after an accepted pop, the read enable is high, the select code equals the buffer number, and the read address holds the byte's ring position.
- R6: A write rewind drops the uncommitted bytes, so the next push reuses the address of the first dropped byte.
- R7: A read rewind returns the reader to the start of the current set.
- R8: A release frees the current set's space, so full clears. The write address wraps around the ring.
- R9: The two-level buffer holds two committed sets. It reports full while both are queued. The reader cannot pass the end of the first set until that set is released.
- R10: The two-level buffer also reports full once BIG_DEPTH bytes are held, whether or not they are committed.
- R11: When a write and a read occur in the same cycle, the write is applied first. A pop issued alongside a commit can read the new set. A push to a full buffer issued alongside a release is still refused.
- R12: After reset, every buffer is empty and not full, all strobes are high and the read enable is low.
- R13: On a single-level buffer, a second commit made before release extends the readable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_wr_op | input | 3 | Transmit write operation code |
| tx_wr_ep | input | EP_W | Transmit write endpoint |
| tx_wr_data | input | 8 | Transmit write byte |
| tx_rd_op | input | 3 | Transmit read operation code |
| tx_rd_ep | input | EP_W | Transmit read endpoint |
| rx_wr_op | input | 3 | Receive write operation code |
| rx_wr_ep | input | EP_W | Receive write endpoint |
| rx_wr_data | input | 8 | Receive write byte |
| rx_rd_op | input | 3 | Receive read operation code |
| rx_rd_ep | input | EP_W | Receive read endpoint |
| tx_ram_wdata | output | 8 | Shared transmit RAM write data |
| tx_ram_wr_ptr | output | PTR_W | Shared transmit RAM write address |
| tx_ram_rd_ptr | output | PTR_W | Shared transmit RAM read address |
| tx_ram_wr_n | output | N_STB | Transmit RAM write strobes, active low |
| tx_ram_sel | output | 3 | Transmit RAM read select |
| tx_ram_rd_en | output | 1 | Transmit RAM read enable |
| tx_full | output | 4 | Transmit buffer full flags |
| tx_empty | output | 4 | Transmit buffer empty flags |
| rx_ram_wdata | output | 8 | Shared receive RAM write data |
| rx_ram_wr_ptr | output | PTR_W | Shared receive RAM write address |
| rx_ram_rd_ptr | output | PTR_W | Shared receive RAM read address |
| rx_ram_wr_n | output | N_STB | Receive RAM write strobes, active low |
| rx_ram_sel | output | 3 | Receive RAM read select |
| rx_ram_rd_en | output | 1 | Receive RAM read enable |
| rx_full | output | 4 | Receive buffer full flags |
| rx_empty | output | 4 | Receive buffer empty flags |

## Verification
The bench uses 4-byte single-level buffers and an 8-byte two-level buffer. With these sizes it can sweep every fill level, including the step to full and the ring wrap. A design that miscounted occupancy would strobe a RAM for a byte it had no room for, or would never raise full. The bench also tests the set boundary in the two-level buffer. A design that merged the two sets would accept a third pop before the release. Both rewinds are checked by their effect on the next address. The same-cycle write-and-read cases are checked too. Evaluating the read before the write would refuse the pop that comes with a commit, and it would accept the push that comes with a release into a full buffer.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;
  localparam int EP_W  = 4;
  localparam int N_BUF = 4;

  localparam logic [2:0] WOP_NONE   = 3'd0;
  localparam logic [2:0] WOP_PUSH   = 3'd1;
  localparam logic [2:0] WOP_PUSHC  = 3'd2;
  localparam logic [2:0] WOP_COMMIT = 3'd3;
  localparam logic [2:0] WOP_REWIND = 3'd4;

  localparam logic [2:0] ROP_NONE   = 3'd0;
  localparam logic [2:0] ROP_POP    = 3'd1;
  localparam logic [2:0] ROP_POPR   = 3'd2;
  localparam logic [2:0] ROP_REL    = 3'd3;
  localparam logic [2:0] ROP_REWIND = 3'd4;
endpackage

// File: rtl/epbuf_slot.sv
module epbuf_slot
  import epbuf_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter bit TWO_LEVEL = 1'b0,
  parameter int PTR_W     = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [2:0]       wr_op,
  input  logic             rd_hit,
  input  logic [2:0]       rd_op,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [PTR_W-1:0] wr_addr,
  output logic [PTR_W-1:0] rd_addr,
  output logic             full,
  output logic             empty
);
  localparam int AW     = $clog2(DEPTH);
  localparam int CW     = AW + 1;
  localparam int LEVELS = TWO_LEVEL ? 2 : 1;

  initial begin
    if ((1 << AW) != DEPTH) $error("DEPTH must be a power of two");
    if (AW > PTR_W) $error("DEPTH exceeds pointer range");
  end

  logic [CW-1:0] wp, ws, rp, rs, len0, len1;
  logic [1:0]    nsets;

  logic [CW-1:0] wp_n, ws_n, rp_n, rs_n, l0_n, l1_n, occ, new_len;
  logic [1:0]    ns_n;
  logic          byte_full, slot_full, do_commit, do_rel, avail;

  always_comb begin
    occ       = wp - rs;
    byte_full = (occ == CW'(DEPTH));
    slot_full = TWO_LEVEL && (nsets == 2'd2);
    full      = byte_full || slot_full;
    empty     = (nsets == 2'd0);

    // write side first
    wp_n = wp; ws_n = ws; l0_n = len0; l1_n = len1; ns_n = nsets;
    push_ok = wr_hit && (wr_op == WOP_PUSH || wr_op == WOP_PUSHC) && !full;
    if (push_ok) wp_n = wp + 1'b1;
    if (wr_hit && wr_op == WOP_REWIND) wp_n = ws;
    do_commit = wr_hit && ((wr_op == WOP_PUSHC && push_ok) || wr_op == WOP_COMMIT);
    new_len = wp_n - ws;
    if (do_commit && new_len != '0) begin
      if (ns_n == 2'd0) begin
        l0_n = new_len;
        ns_n = 2'd1;
      end else if (TWO_LEVEL) begin
        l1_n = new_len;
        ns_n = 2'd2;
      end else begin
        l0_n = l0_n + new_len;
      end
      ws_n = wp_n;
    end

    // read side sees the post-write state
    rp_n = rp; rs_n = rs;
    avail  = (ns_n != 2'd0) && ((rp - rs) != l0_n);
    pop_ok = rd_hit && (rd_op == ROP_POP || rd_op == ROP_POPR) && avail;
    if (pop_ok) rp_n = rp + 1'b1;
    if (rd_hit && rd_op == ROP_REWIND) rp_n = rs;
    do_rel = rd_hit && ((rd_op == ROP_POPR && pop_ok) || rd_op == ROP_REL) && (ns_n != 2'd0);
    if (do_rel) begin
      rs_n = rs + l0_n;
      rp_n = rs + l0_n;
      if (TWO_LEVEL) l0_n = l1_n;
      ns_n = ns_n - 2'd1;
    end
  end

  assign wr_addr = PTR_W'(wp[AW-1:0]);
  assign rd_addr = PTR_W'(rp[AW-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; ws <= '0; rp <= '0; rs <= '0;
      len0 <= '0; len1 <= '0; nsets <= '0;
    end else begin
      wp <= wp_n; ws <= ws_n; rp <= rp_n; rs <= rs_n;
      len0 <= l0_n; len1 <= l1_n; nsets <= ns_n;
    end
  end

  p_occ_bound_r3: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH)) else $error("occupancy above depth");
  p_sets_bound_r9: assert property (@(posedge clk) disable iff (rst)
    int'(nsets) <= LEVELS) else $error("too many queued sets");
  p_full_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    (full && wr_hit && wr_op == WOP_PUSH) |=> wp == $past(wp))
    else $error("push into full buffer moved the pointer");
  p_empty_no_pop_r4: assert property (@(posedge clk) disable iff (rst)
    (empty && !wr_hit && rd_hit && rd_op == ROP_POP) |-> !pop_ok)
    else $error("pop accepted from empty buffer");
  p_wr_rewind_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wr_op == WOP_REWIND) |=> wp == $past(ws))
    else $error("write rewind missed set start");
endmodule

// File: rtl/epbuf_dir.sv
module epbuf_dir
  import epbuf_pkg::*;
#(
  parameter logic [N_BUF*EP_W-1:0] EP_MAP = '0,
  parameter int SMALL_DEPTH = 64,
  parameter int BIG_DEPTH   = 512,
  parameter int PTR_W       = 9,
  parameter int N_STB       = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       wr_op,
  input  logic [EP_W-1:0]  wr_ep,
  input  logic [7:0]       wr_data,
  input  logic [2:0]       rd_op,
  input  logic [EP_W-1:0]  rd_ep,
  output logic [7:0]       ram_wdata,
  output logic [PTR_W-1:0] ram_wr_ptr,
  output logic [PTR_W-1:0] ram_rd_ptr,
  output logic [N_STB-1:0] ram_wr_n,
  output logic [2:0]       ram_sel,
  output logic             ram_rd_en,
  output logic [N_BUF-1:0] full,
  output logic [N_BUF-1:0] empty
);
  localparam int BIG_IDX = N_BUF - 1;

  logic [N_BUF-1:0] wr_hit, rd_hit, push_ok, pop_ok;
  logic [PTR_W-1:0] waddr [N_BUF];
  logic [PTR_W-1:0] raddr [N_BUF];

  for (genvar i = 0; i < N_BUF; i++) begin : g_buf
    assign wr_hit[i] = (wr_ep == EP_MAP[i*EP_W +: EP_W]);
    assign rd_hit[i] = (rd_ep == EP_MAP[i*EP_W +: EP_W]);
    epbuf_slot #(
      .DEPTH    (i == BIG_IDX ? BIG_DEPTH : SMALL_DEPTH),
      .TWO_LEVEL(i == BIG_IDX),
      .PTR_W    (PTR_W)
    ) u_slot (
      .clk    (clk),
      .rst    (rst),
      .wr_hit (wr_hit[i]),
      .wr_op  (wr_op),
      .rd_hit (rd_hit[i]),
      .rd_op  (rd_op),
      .push_ok(push_ok[i]),
      .pop_ok (pop_ok[i]),
      .wr_addr(waddr[i]),
      .rd_addr(raddr[i]),
      .full   (full[i]),
      .empty  (empty[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_wdata  <= '0;
      ram_wr_ptr <= '0;
      ram_rd_ptr <= '0;
      ram_wr_n   <= '1;
      ram_sel    <= '0;
      ram_rd_en  <= 1'b0;
    end else begin
      ram_wr_n  <= '1;
      ram_rd_en <= |pop_ok;
      for (int i = 0; i < N_BUF; i++) begin
        if (push_ok[i]) begin
          ram_wr_n[i] <= 1'b0;
          ram_wr_ptr  <= waddr[i];
          ram_wdata   <= wr_data;
        end
        if (pop_ok[i]) begin
          ram_rd_ptr <= raddr[i];
          ram_sel    <= 3'(i);
        end
      end
    end
  end

  p_strobe_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(~ram_wr_n) <= 1) else $error("several strobes low");
  p_spare_high_r2: assert property (@(posedge clk) disable iff (rst)
    &ram_wr_n[N_STB-1:N_BUF]) else $error("spare strobe driven");
  p_sel_range_r5: assert property (@(posedge clk) disable iff (rst)
    ram_rd_en |-> int'(ram_sel) < N_BUF) else $error("select out of range");
  p_map_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hit) && $onehot0(rd_hit)) else $error("endpoint maps twice");
endmodule

// File: rtl/epbuf_ctrl.sv
module epbuf_ctrl
  import epbuf_pkg::*;
#(
  parameter int SMALL_DEPTH = 64,
  parameter int BIG_DEPTH   = 512,
  parameter int PTR_W       = 9,
  parameter int N_STB       = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       tx_wr_op,
  input  logic [EP_W-1:0]  tx_wr_ep,
  input  logic [7:0]       tx_wr_data,
  input  logic [2:0]       tx_rd_op,
  input  logic [EP_W-1:0]  tx_rd_ep,
  input  logic [2:0]       rx_wr_op,
  input  logic [EP_W-1:0]  rx_wr_ep,
  input  logic [7:0]       rx_wr_data,
  input  logic [2:0]       rx_rd_op,
  input  logic [EP_W-1:0]  rx_rd_ep,
  output logic [7:0]       tx_ram_wdata,
  output logic [PTR_W-1:0] tx_ram_wr_ptr,
  output logic [PTR_W-1:0] tx_ram_rd_ptr,
  output logic [N_STB-1:0] tx_ram_wr_n,
  output logic [2:0]       tx_ram_sel,
  output logic             tx_ram_rd_en,
  output logic [N_BUF-1:0] tx_full,
  output logic [N_BUF-1:0] tx_empty,
  output logic [7:0]       rx_ram_wdata,
  output logic [PTR_W-1:0] rx_ram_wr_ptr,
  output logic [PTR_W-1:0] rx_ram_rd_ptr,
  output logic [N_STB-1:0] rx_ram_wr_n,
  output logic [2:0]       rx_ram_sel,
  output logic             rx_ram_rd_en,
  output logic [N_BUF-1:0] rx_full,
  output logic [N_BUF-1:0] rx_empty
);
  localparam logic [N_BUF*EP_W-1:0] TX_MAP = {4'd7, 4'd6, 4'd5, 4'd0};
  localparam logic [N_BUF*EP_W-1:0] RX_MAP = {4'd3, 4'd2, 4'd1, 4'd0};

  epbuf_dir #(.EP_MAP(TX_MAP), .SMALL_DEPTH(SMALL_DEPTH), .BIG_DEPTH(BIG_DEPTH),
              .PTR_W(PTR_W), .N_STB(N_STB)) u_tx (
    .clk(clk), .rst(rst),
    .wr_op(tx_wr_op), .wr_ep(tx_wr_ep), .wr_data(tx_wr_data),
    .rd_op(tx_rd_op), .rd_ep(tx_rd_ep),
    .ram_wdata(tx_ram_wdata), .ram_wr_ptr(tx_ram_wr_ptr), .ram_rd_ptr(tx_ram_rd_ptr),
    .ram_wr_n(tx_ram_wr_n), .ram_sel(tx_ram_sel), .ram_rd_en(tx_ram_rd_en),
    .full(tx_full), .empty(tx_empty)
  );

  epbuf_dir #(.EP_MAP(RX_MAP), .SMALL_DEPTH(SMALL_DEPTH), .BIG_DEPTH(BIG_DEPTH),
              .PTR_W(PTR_W), .N_STB(N_STB)) u_rx (
    .clk(clk), .rst(rst),
    .wr_op(rx_wr_op), .wr_ep(rx_wr_ep), .wr_data(rx_wr_data),
    .rd_op(rx_rd_op), .rd_ep(rx_rd_ep),
    .ram_wdata(rx_ram_wdata), .ram_wr_ptr(rx_ram_wr_ptr), .ram_rd_ptr(rx_ram_rd_ptr),
    .ram_wr_n(rx_ram_wr_n), .ram_sel(rx_ram_sel), .ram_rd_en(rx_ram_rd_en),
    .full(rx_full), .empty(rx_empty)
  );
endmodule

// File: tb/test_epbuf_ctrl.sv
module test_epbuf_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SD = 4;
  localparam int BD = 8;
  localparam int PW = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] tx_wr_op = 0, tx_rd_op = 0, rx_wr_op = 0, rx_rd_op = 0;
  logic [3:0] tx_wr_ep = 0, tx_rd_ep = 0, rx_wr_ep = 0, rx_rd_ep = 0;
  logic [7:0] tx_wr_data = 0, rx_wr_data = 0;
  logic [7:0] tx_ram_wdata, rx_ram_wdata;
  logic [PW-1:0] tx_ram_wr_ptr, tx_ram_rd_ptr, rx_ram_wr_ptr, rx_ram_rd_ptr;
  logic [6:0] tx_ram_wr_n, rx_ram_wr_n;
  logic [2:0] tx_ram_sel, rx_ram_sel;
  logic tx_ram_rd_en, rx_ram_rd_en;
  logic [3:0] tx_full, tx_empty, rx_full, rx_empty;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  epbuf_ctrl #(.SMALL_DEPTH(SD), .BIG_DEPTH(BD), .PTR_W(PW), .N_STB(7)) i_epbuf_ctrl (
    .clk(clk), .rst(rst),
    .tx_wr_op(tx_wr_op), .tx_wr_ep(tx_wr_ep), .tx_wr_data(tx_wr_data),
    .tx_rd_op(tx_rd_op), .tx_rd_ep(tx_rd_ep),
    .rx_wr_op(rx_wr_op), .rx_wr_ep(rx_wr_ep), .rx_wr_data(rx_wr_data),
    .rx_rd_op(rx_rd_op), .rx_rd_ep(rx_rd_ep),
    .tx_ram_wdata(tx_ram_wdata), .tx_ram_wr_ptr(tx_ram_wr_ptr), .tx_ram_rd_ptr(tx_ram_rd_ptr),
    .tx_ram_wr_n(tx_ram_wr_n), .tx_ram_sel(tx_ram_sel), .tx_ram_rd_en(tx_ram_rd_en),
    .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_ram_wdata(rx_ram_wdata), .rx_ram_wr_ptr(rx_ram_wr_ptr), .rx_ram_rd_ptr(rx_ram_rd_ptr),
    .rx_ram_wr_n(rx_ram_wr_n), .rx_ram_sel(rx_ram_sel), .rx_ram_rd_en(rx_ram_rd_en),
    .rx_full(rx_full), .rx_empty(rx_empty)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic tw(input logic [2:0] op, input logic [3:0] ep, input logic [7:0] d);
    tx_wr_op = op; tx_wr_ep = ep; tx_wr_data = d;
    tick();
    tx_wr_op = 0;
  endtask

  task automatic tr(input logic [2:0] op, input logic [3:0] ep);
    tx_rd_op = op; tx_rd_ep = ep;
    tick();
    tx_rd_op = 0;
  endtask

  task automatic rw(input logic [2:0] op, input logic [3:0] ep, input logic [7:0] d);
    rx_wr_op = op; rx_wr_ep = ep; rx_wr_data = d;
    tick();
    rx_wr_op = 0;
  endtask

  task automatic rr(input logic [2:0] op, input logic [3:0] ep);
    rx_rd_op = op; rx_rd_ep = ep;
    tick();
    rx_rd_op = 0;
  endtask

  function automatic int strb(input int b);
    return 7'h7F ^ (1 << b);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int tx_eps[4] = '{0, 5, 6, 7};
    do_reset();
    // R12 reset state
    chk("R12 tx_empty", tx_empty, 4'hF);
    chk("R12 tx_full", tx_full, 0);
    chk("R12 rx_empty", rx_empty, 4'hF);
    chk("R12 strobes", tx_ram_wr_n, 7'h7F);
    chk("R12 rd_en", tx_ram_rd_en, 0);

    // R1 / R2 transmit endpoint sweep
    for (int k = 0; k < 4; k++) begin
      tw(3'd1, 4'(tx_eps[k]), 8'(8'h10 + k));
      chk("R1 tx strobe", tx_ram_wr_n, strb(k));
      chk("R2 wdata", tx_ram_wdata, 8'h10 + k);
      chk("R2 wr_ptr", tx_ram_wr_ptr, 0);
      tick();
      chk("R2 strobe released", tx_ram_wr_n, 7'h7F);
    end
    tw(3'd1, 4'd3, 8'h55);
    chk("R1 unmapped tx ignored", tx_ram_wr_n, 7'h7F);
    tw(3'd2, 4'd9, 8'h55);
    chk("R1 unmapped tx empty", tx_empty, 4'hF);

    // R1 / R5 receive side
    do_reset();
    for (int k = 0; k < 4; k++) begin
      rw(3'd2, 4'(k), 8'(k));
      chk("R1 rx strobe", rx_ram_wr_n, strb(k));
    end
    rw(3'd1, 4'd5, 8'h0);
    chk("R1 rx unmapped", rx_ram_wr_n, 7'h7F);
    chk("R1 rx all committed", rx_empty, 0);
    rr(3'd1, 4'd2);
    chk("R5 rx rd_en", rx_ram_rd_en, 1);
    chk("R5 rx sel", rx_ram_sel, 2);
    chk("R5 rx rd_ptr", rx_ram_rd_ptr, 0);
    rr(3'd1, 4'd9);
    chk("R1 rx unmapped pop", rx_ram_rd_en, 0);

    // R3 / R4 / R5 / R8 small buffer, endpoint 5 (buffer 1)
    do_reset();
    for (int i = 0; i < SD; i++) begin
      tw(3'd1, 4'd5, 8'(i));
      chk("R2 fill address", tx_ram_wr_ptr, i);
      chk("R3 full at depth", tx_full[1], int'(i == SD - 1));
    end
    tw(3'd1, 4'd5, 8'h99);
    chk("R3 push on full ignored", tx_ram_wr_n, 7'h7F);
    chk("R4 empty before commit", tx_empty[1], 1);
    tr(3'd1, 4'd5);
    chk("R4 pop on empty", tx_ram_rd_en, 0);
    tw(3'd3, 4'd5, 8'h0);
    chk("R4 empty after commit", tx_empty[1], 0);
    for (int i = 0; i < SD; i++) begin
      tr(3'd1, 4'd5);
      chk("R5 rd_en", tx_ram_rd_en, 1);
      chk("R5 rd_ptr", tx_ram_rd_ptr, i);
      chk("R5 sel", tx_ram_sel, 1);
    end
    tr(3'd1, 4'd5);
    chk("R4 pop past set end", tx_ram_rd_en, 0);
    tr(3'd3, 4'd5);
    chk("R8 full clears", tx_full[1], 0);
    chk("R8 empty after release", tx_empty[1], 1);
    tw(3'd1, 4'd5, 8'h0);
    chk("R8 wrap address", tx_ram_wr_ptr, 0);
    // R13 merge of commits
    tw(3'd3, 4'd5, 8'h0);
    tw(3'd2, 4'd5, 8'h1);
    for (int i = 0; i < 3; i++) begin
      tr(3'd1, 4'd5);
      chk("R13 merged set pop", tx_ram_rd_en, int'(i < 2));
    end

    // R7 read rewind, endpoint 0
    do_reset();
    tw(3'd1, 4'd0, 8'h0); tw(3'd1, 4'd0, 8'h1); tw(3'd2, 4'd0, 8'h2);
    tr(3'd1, 4'd0); tr(3'd1, 4'd0);
    chk("R7 before rewind", tx_ram_rd_ptr, 1);
    tr(3'd4, 4'd0);
    tr(3'd1, 4'd0);
    chk("R7 rewind to set start", tx_ram_rd_ptr, 0);

    // R6 write rewind, endpoint 6
    tw(3'd1, 4'd6, 8'h0); tw(3'd1, 4'd6, 8'h1);
    chk("R6 before rewind", tx_ram_wr_ptr, 1);
    tw(3'd4, 4'd6, 8'h0);
    tw(3'd2, 4'd6, 8'h7);
    chk("R6 reuse address", tx_ram_wr_ptr, 0);
    tr(3'd1, 4'd6);
    chk("R6 one byte readable", tx_ram_rd_en, 1);
    tr(3'd1, 4'd6);
    chk("R6 dropped bytes gone", tx_ram_rd_en, 0);

    // R9 two-level buffer, endpoint 7
    do_reset();
    tw(3'd1, 4'd7, 8'h0); tw(3'd2, 4'd7, 8'h1);
    chk("R9 one set not full", tx_full[3], 0);
    tw(3'd1, 4'd7, 8'h2); tw(3'd1, 4'd7, 8'h3); tw(3'd2, 4'd7, 8'h4);
    chk("R9 full on two sets", tx_full[3], 1);
    tw(3'd1, 4'd7, 8'h5);
    chk("R9 push refused", tx_ram_wr_n, 7'h7F);
    for (int i = 0; i < 3; i++) begin
      tr(3'd1, 4'd7);
      chk("R9 first set boundary", tx_ram_rd_en, int'(i < 2));
    end
    tr(3'd3, 4'd7);
    chk("R9 slot freed", tx_full[3], 0);
    chk("R9 second set pending", tx_empty[3], 0);
    for (int i = 0; i < 4; i++) begin
      tr(3'd1, 4'd7);
      chk("R9 second set pop", tx_ram_rd_en, int'(i < 3));
      if (i < 3) chk("R9 second set addr", tx_ram_rd_ptr, 2 + i);
    end
    tr(3'd3, 4'd7);
    chk("R9 empty after both", tx_empty[3], 1);

    // R10 byte capacity of two-level buffer
    do_reset();
    for (int i = 0; i <= BD; i++) begin
      tw(3'd1, 4'd7, 8'(i));
      if (i < BD) begin
        chk("R10 accepted", tx_ram_wr_n, strb(3));
        chk("R10 full level", tx_full[3], int'(i == BD - 1));
      end else begin
        chk("R10 refused", tx_ram_wr_n, 7'h7F);
      end
    end

    // R11 write-first ordering, endpoint 6
    do_reset();
    tx_wr_op = 3'd2; tx_wr_ep = 4'd6; tx_wr_data = 8'hA0;
    tx_rd_op = 3'd1; tx_rd_ep = 4'd6;
    tick();
    tx_wr_op = 0; tx_rd_op = 0;
    chk("R11 pop with commit", tx_ram_rd_en, 1);
    chk("R11 pop addr", tx_ram_rd_ptr, 0);
    for (int i = 0; i < 3; i++) tw(3'd1, 4'd6, 8'(i));
    chk("R11 full before", tx_full[2], 1);
    tx_wr_op = 3'd1; tx_wr_ep = 4'd6;
    tx_rd_op = 3'd3; tx_rd_ep = 4'd6;
    tick();
    tx_wr_op = 0; tx_rd_op = 0;
    chk("R11 push refused beside release", tx_ram_wr_n, 7'h7F);
    chk("R11 full cleared", tx_full[2], 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule